// File: doc/BRIEF.md
# Paged Address Translation Table

This block translates addresses in a virtual window into addresses in an external physical memory. It works in fixed-size pages. A table of page entries holds, for each virtual page, a physical page number, a valid flag and a sensitive flag. The page size is chosen at run time by a 2-bit code, giving pages of 8 KB to 64 KB. The table index and the in-page offset therefore move with that code.

Software does not address the table directly. It first loads an index register. Every later content write or content read then goes to the selected entry. A content write stores the page number and marks the entry valid. A reserved write word clears the entry instead. The sensitive flag of a written entry follows the parity of an external 3-bit counter: an odd number of set bits means protection is active.

On the lookup side, a requester presents a virtual address. One clock later the block answers. It returns either a hit with the physical address and the entry's sensitive flag, or a fault pulse when the entry is missing or not valid.

Top module: `paged_xlate_table`

## Requirements
- R1: After reset every entry is invalid, `rd_page` is 0, and `lk_ack`, `lk_hit`, `lk_fault` and `lk_secure` are 0.
- R2: A pulse on `idx_wr` loads the entry index register from `idx_wdata`. A later `ent_wr` stores `ent_wdata[11:0]` as the page number of that entry and marks it valid. From the next cycle `rd_page` shows that page number.
- R3: The `ent_wr` word 16'h8000 makes the selected entry invalid. `rd_page` reads 0 for any entry that is not valid.
- R4: An entry written while `crypt_cnt` has an odd number of set bits is marked sensitive, and one written with an even count is not. A hit reports the flag on `lk_secure`. `rd_page` never carries the flag.
- R5: `pg_code` selects the page shift: 0 gives 16 (64 KB), 1 gives 15, 2 gives 14 and 3 gives 13. The entry index is bits [23:0] of the virtual address shifted right by the page shift.
- R6: A lookup requested in one cycle is answered in the next cycle with `lk_ack`. On a hit, `lk_paddr` is the stored page shifted left by the page shift, ORed with the virtual address bits below the shift.
- R7: A lookup whose index is 256 or more, or whose entry is invalid, gives `lk_fault`=1, `lk_hit`=0 and `lk_paddr`=0 for one cycle.
- R8: Virtual address bits [31:24] have no effect on a lookup.
- R9: A new `pg_code` applies to a lookup requested in the same cycle. Stored entries are kept when the code changes.
- R10: A content write and a lookup of the same entry in the same cycle: the lookup sees the entry as it was before the write. An index write and a content write in the same cycle: the content goes to the previously selected entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_code | input | 2 | Page size code |
| crypt_cnt | input | 3 | External counter; odd parity turns protection on |
| idx_wr | input | 1 | Load entry index register |
| idx_wdata | input | 8 | New entry index |
| ent_wr | input | 1 | Write the selected entry |
| ent_wdata | input | 16 | Page number in bits [11:0], or the invalidate word |
| rd_page | output | 12 | Page number of the selected entry, 0 if invalid |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_ack | output | 1 | Lookup answer strobe |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_fault | output | 1 | Lookup hit an invalid or out-of-range entry |
| lk_secure | output | 1 | Sensitive flag of the hit entry |
| lk_paddr | output | 28 | Translated physical address |

## Verification
A lookup can land in the same cycle as a content write to the very entry it indexes. It can also land in the same cycle as a page-size change. The bench drives a lookup and a content write to the same selected entry on one clock edge. It expects the old page in the answer and the new page from a lookup one cycle later. A second scenario writes the index register and the content register together. It then confirms by read-back that only the previously selected entry changed.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

    typedef enum logic [1:0] {
        PG_64K = 2'd0,
        PG_32K = 2'd1,
        PG_16K = 2'd2,
        PG_8K  = 2'd3
    } pg_size_e;

    // Bit position of the page boundary for each size code
    function automatic logic [4:0] pg_shift(input logic [1:0] code);
        case (pg_size_e'(code))
            PG_64K:  return 5'd16;
            PG_32K:  return 5'd15;
            PG_16K:  return 5'd14;
            default: return 5'd13;
        endcase
    endfunction

endpackage

// File: rtl/mmu_page_table.sv
module mmu_page_table #(
    parameter int ENTRIES = 256,
    parameter int PAGE_W  = 12,
    parameter int WD_W    = 16,
    parameter logic [WD_W-1:0] INV_WORD = 16'h8000,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crypt_on,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic              ent_wr,
    input  logic [WD_W-1:0]   ent_wdata,
    output logic [PAGE_W-1:0] rd_page,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic              lk_sens,
    output logic [PAGE_W-1:0] lk_page
);

    typedef struct packed {
        logic              sens;
        logic              valid;
        logic [PAGE_W-1:0] page;
    } entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } sel_t;

    sel_t   sel_d, sel_q;
    entry_t tab_d [ENTRIES];
    entry_t tab_q [ENTRIES];

    always_comb begin
        sel_d = sel_q;
        tab_d = tab_q;
        // content write uses the index held before this edge
        if (ent_wr) begin
            if (ent_wdata == INV_WORD) begin
                tab_d[sel_q.idx] = '0;
            end else begin
                tab_d[sel_q.idx] = '{sens: crypt_on, valid: 1'b1,
                                     page: ent_wdata[PAGE_W-1:0]};
            end
        end
        if (idx_wr) begin
            sel_d.idx = idx_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            sel_q <= sel_d;
            tab_q <= tab_d;
        end
    end

    always_comb begin
        rd_page  = tab_q[sel_q.idx].valid ? tab_q[sel_q.idx].page : '0;
        lk_valid = tab_q[lk_idx].valid;
        lk_sens  = tab_q[lk_idx].sens;
        lk_page  = tab_q[lk_idx].page;
    end

endmodule

// File: rtl/mmu_xlate_lookup.sv
module mmu_xlate_lookup
    import mmu_xlate_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int PAGE_W  = 12,
    parameter int VA_W    = 24,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PAGE_W + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pg_code,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic [IDX_W-1:0]  tb_idx,
    input  logic              tb_valid,
    input  logic              tb_sens,
    input  logic [PAGE_W-1:0] tb_page,
    output logic              lk_ack,
    output logic              lk_hit,
    output logic              lk_fault,
    output logic              lk_secure,
    output logic [PA_W-1:0]   lk_paddr
);

    localparam logic [ADDR_W-1:0] LIN_MASK = ADDR_W'((64'd1 << VA_W) - 64'd1);

    typedef struct packed {
        logic            ack;
        logic            hit;
        logic            fault;
        logic            secure;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [4:0]        sh;
    logic [ADDR_W-1:0] lin;
    logic [ADDR_W-1:0] vpn;
    logic              oor;
    logic [PA_W-1:0]   off_mask;
    logic [PA_W-1:0]   pa;

    always_comb begin
        sh       = pg_shift(pg_code);
        lin      = lk_vaddr & LIN_MASK;
        vpn      = lin >> sh;
        oor      = |(vpn >> IDX_W);
        tb_idx   = vpn[IDX_W-1:0];
        off_mask = (PA_W'(1) << sh) - PA_W'(1);
        pa       = (PA_W'(tb_page) << sh) | (PA_W'(lin) & off_mask);

        rsp_d        = '0;
        rsp_d.ack    = lk_req;
        if (lk_req) begin
            if (!oor && tb_valid) begin
                rsp_d.hit    = 1'b1;
                rsp_d.secure = tb_sens;
                rsp_d.paddr  = pa;
            end else begin
                rsp_d.fault  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign lk_ack    = rsp_q.ack;
    assign lk_hit    = rsp_q.hit;
    assign lk_fault  = rsp_q.fault;
    assign lk_secure = rsp_q.secure;
    assign lk_paddr  = rsp_q.paddr;

endmodule

// File: rtl/paged_xlate_table.sv
module paged_xlate_table #(
    parameter int ENTRIES = 256,
    parameter int PAGE_W  = 12,
    parameter int VA_W    = 24,
    parameter int ADDR_W  = 32,
    parameter int WD_W    = 16,
    parameter logic [WD_W-1:0] INV_WORD = 16'h8000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  pg_code,
    input  logic [2:0]                  crypt_cnt,
    input  logic                        idx_wr,
    input  logic [$clog2(ENTRIES)-1:0]  idx_wdata,
    input  logic                        ent_wr,
    input  logic [WD_W-1:0]             ent_wdata,
    output logic [PAGE_W-1:0]           rd_page,
    input  logic                        lk_req,
    input  logic [ADDR_W-1:0]           lk_vaddr,
    output logic                        lk_ack,
    output logic                        lk_hit,
    output logic                        lk_fault,
    output logic                        lk_secure,
    output logic [PAGE_W+15:0]          lk_paddr
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic              crypt_on;
    logic [IDX_W-1:0]  tb_idx;
    logic              tb_valid;
    logic              tb_sens;
    logic [PAGE_W-1:0] tb_page;

    // odd number of set counter bits turns protection on
    assign crypt_on = ^crypt_cnt;

    mmu_page_table #(
        .ENTRIES (ENTRIES),
        .PAGE_W  (PAGE_W),
        .WD_W    (WD_W),
        .INV_WORD(INV_WORD)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .crypt_on (crypt_on),
        .idx_wr   (idx_wr),
        .idx_wdata(idx_wdata),
        .ent_wr   (ent_wr),
        .ent_wdata(ent_wdata),
        .rd_page  (rd_page),
        .lk_idx   (tb_idx),
        .lk_valid (tb_valid),
        .lk_sens  (tb_sens),
        .lk_page  (tb_page)
    );

    mmu_xlate_lookup #(
        .ENTRIES(ENTRIES),
        .PAGE_W (PAGE_W),
        .VA_W   (VA_W),
        .ADDR_W (ADDR_W)
    ) lookup_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_code  (pg_code),
        .lk_req   (lk_req),
        .lk_vaddr (lk_vaddr),
        .tb_idx   (tb_idx),
        .tb_valid (tb_valid),
        .tb_sens  (tb_sens),
        .tb_page  (tb_page),
        .lk_ack   (lk_ack),
        .lk_hit   (lk_hit),
        .lk_fault (lk_fault),
        .lk_secure(lk_secure),
        .lk_paddr (lk_paddr)
    );

endmodule

// File: rtl/paged_xlate_table_chk.sv
module paged_xlate_table_chk #(
    parameter int PAGE_W = 12,
    parameter int WD_W   = 16,
    parameter int ADDR_W = 32,
    parameter logic [WD_W-1:0] INV_WORD = 16'h8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idx_wr,
    input logic              ent_wr,
    input logic [WD_W-1:0]   ent_wdata,
    input logic [PAGE_W-1:0] rd_page,
    input logic              lk_req,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic              lk_ack,
    input logic              lk_hit,
    input logic              lk_fault,
    input logic              lk_secure,
    input logic [PAGE_W+15:0] lk_paddr
);

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_ack); // R6

    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_ack && !lk_hit && !lk_fault); // R6

    AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ack |-> (lk_hit != lk_fault)); // R7

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_paddr == '0) && !lk_secure); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[12:0] == $past(lk_vaddr[12:0])); // R6

    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr && !idx_wr && ent_wdata != INV_WORD) |=>
        rd_page == $past(ent_wdata[PAGE_W-1:0])); // R2

    AST_RD_AFTER_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr && !idx_wr && ent_wdata == INV_WORD) |=> rd_page == '0); // R3

endmodule

bind paged_xlate_table paged_xlate_table_chk #(
    .PAGE_W  (PAGE_W),
    .WD_W    (WD_W),
    .ADDR_W  (ADDR_W),
    .INV_WORD(INV_WORD)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .ent_wr   (ent_wr),
    .ent_wdata(ent_wdata),
    .rd_page  (rd_page),
    .lk_req   (lk_req),
    .lk_vaddr (lk_vaddr),
    .lk_ack   (lk_ack),
    .lk_hit   (lk_hit),
    .lk_fault (lk_fault),
    .lk_secure(lk_secure),
    .lk_paddr (lk_paddr)
);

// File: tb/paged_xlate_table_tb_top.sv
module paged_xlate_table_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pg_code = 2'd0;
    logic [2:0]  crypt_cnt = 3'd0;
    logic        idx_wr = 1'b0;
    logic [7:0]  idx_wdata = '0;
    logic        ent_wr = 1'b0;
    logic [15:0] ent_wdata = '0;
    logic [11:0] rd_page;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_ack, lk_hit, lk_fault, lk_secure;
    logic [27:0] lk_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    paged_xlate_table dut_i (
        .clk(clk), .rst_n(rst_n), .pg_code(pg_code), .crypt_cnt(crypt_cnt),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata), .ent_wr(ent_wr),
        .ent_wdata(ent_wdata), .rd_page(rd_page), .lk_req(lk_req),
        .lk_vaddr(lk_vaddr), .lk_ack(lk_ack), .lk_hit(lk_hit),
        .lk_fault(lk_fault), .lk_secure(lk_secure), .lk_paddr(lk_paddr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int shift_of(input logic [1:0] c);
        return 16 - int'(c);
    endfunction

    function automatic logic [27:0] exp_pa(input logic [11:0] pg,
                                           input logic [31:0] va,
                                           input logic [1:0] c);
        int s = shift_of(c);
        logic [27:0] off = va[27:0] & ((28'd1 << s) - 28'd1);
        return (28'(pg) << s) | off;
    endfunction

    task automatic sel(input logic [7:0] i);
        idx_wr = 1'b1; idx_wdata = i;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    task automatic put(input logic [15:0] w);
        ent_wr = 1'b1; ent_wdata = w;
        @(negedge clk);
        ent_wr = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, output logic ack, output logic hit,
                        output logic flt, output logic sec, output logic [27:0] pa);
        lk_req = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_req = 1'b0;
        ack = lk_ack; hit = lk_hit; flt = lk_fault; sec = lk_secure; pa = lk_paddr;
    endtask

    task automatic t_reset;
        chk("R1", "rd_page", 32'(rd_page), 0);
        chk("R1", "ack/hit/fault/secure",
            {28'd0, lk_ack, lk_hit, lk_fault, lk_secure}, 0);
    endtask

    task automatic t_write_read;
        sel(8'd5); put(16'h0ABC);
        chk("R2", "readback idx5", 32'(rd_page), 32'h0ABC);
        sel(8'd6); put(16'hF321);
        chk("R2", "readback idx6 low bits", 32'(rd_page), 32'h321);
        sel(8'd5);
        chk("R2", "idx5 kept", 32'(rd_page), 32'h0ABC);
    endtask

    task automatic t_invalidate;
        logic a, h, f, s; logic [27:0] p;
        sel(8'd6); put(16'h8000);
        chk("R3", "invalidated reads 0", 32'(rd_page), 0);
        look(32'h0006_0000, a, h, f, s, p);
        chk("R3", "invalidated entry faults", {31'd0, f}, 1);
        sel(8'd200);
        chk("R3", "never written reads 0", 32'(rd_page), 0);
    endtask

    task automatic t_sensitive;
        logic a, h, f, s; logic [27:0] p;
        crypt_cnt = 3'b001; sel(8'd9); put(16'h0123);
        chk("R4", "rd excludes flag", 32'(rd_page), 32'h123);
        crypt_cnt = 3'b011; sel(8'd10); put(16'h0456);
        crypt_cnt = 3'b111; sel(8'd11); put(16'h0789);
        crypt_cnt = 3'b000;
        look(32'h0009_0000, a, h, f, s, p);
        chk("R4", "odd count secure", {30'd0, h, s}, 32'h3);
        look(32'h000A_0000, a, h, f, s, p);
        chk("R4", "even count not secure", {30'd0, h, s}, 32'h2);
        look(32'h000B_0000, a, h, f, s, p);
        chk("R4", "three bits secure", {30'd0, h, s}, 32'h3);
    endtask

    task automatic t_page_sizes;
        logic a, h, f, s; logic [27:0] p;
        for (int c = 0; c < 4; c++) begin
            logic [31:0] va;
            pg_code = 2'(c);
            va = (32'd5 << shift_of(2'(c))) | (32'h0ABC5 & ((32'd1 << shift_of(2'(c))) - 1));
            look(va, a, h, f, s, p);
            chk("R5", $sformatf("hit code %0d", c), {30'd0, a, h}, 32'h3);
            chk("R6", $sformatf("paddr code %0d", c), 32'(p),
                32'(exp_pa(12'hABC, va, 2'(c))));
        end
        pg_code = 2'd0;
    endtask

    task automatic t_out_of_range;
        logic a, h, f, s; logic [27:0] p;
        pg_code = 2'd3;
        look(32'd300 << 13, a, h, f, s, p);
        chk("R7", "index>=256 fault", {29'd0, a, h, f}, 32'h5);
        chk("R7", "fault paddr zero", 32'(p), 0);
        pg_code = 2'd0;
        look(32'h0007_0010, a, h, f, s, p);
        chk("R7", "invalid entry fault", {29'd0, a, h, f}, 32'h5);
        @(negedge clk);
        chk("R7", "fault is a pulse", {31'd0, lk_fault}, 0);
    endtask

    task automatic t_upper_bits;
        logic a, h, f, s; logic [27:0] p;
        look(32'hFF05_0010, a, h, f, s, p);
        chk("R8", "upper bits ignored", 32'(p), 32'h0ABC_0010);
        chk("R8", "upper bits hit", {31'd0, h}, 1);
    endtask

    task automatic t_size_change;
        logic a, h, f, s; logic [27:0] p;
        pg_code = 2'd2;
        look(32'h0001_4008, a, h, f, s, p);
        chk("R9", "new code same cycle", 32'(p), 32'(exp_pa(12'hABC, 32'h0001_4008, 2'd2)));
        pg_code = 2'd0;
        look(32'h0005_0000, a, h, f, s, p);
        chk("R9", "entry kept after change", 32'(p), 32'h0ABC_0000);
    endtask

    task automatic t_collision;
        logic a, h, f, s; logic [27:0] p;
        sel(8'd5);
        ent_wr = 1'b1; ent_wdata = 16'h0456;
        look(32'h0005_0020, a, h, f, s, p);
        ent_wr = 1'b0;
        chk("R10", "lookup sees old entry", 32'(p), 32'h0ABC_0020);
        look(32'h0005_0020, a, h, f, s, p);
        chk("R10", "next lookup sees new entry", 32'(p), 32'h0456_0020);
        idx_wr = 1'b1; idx_wdata = 8'd12;
        ent_wr = 1'b1; ent_wdata = 16'h0777;
        @(negedge clk);
        idx_wr = 1'b0; ent_wr = 1'b0;
        chk("R10", "new index untouched", 32'(rd_page), 0);
        sel(8'd5);
        chk("R10", "old index written", 32'(rd_page), 32'h777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_invalidate();
        t_sensitive();
        t_page_sizes();
        t_out_of_range();
        t_upper_bits();
        t_size_change();
        t_collision();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule